// File: doc/BRIEF.md
# Row-Aware Page-Mode Memory Host Controller

This block sits on the host side of a byte-wide parallel nonvolatile memory that has two chip enables, a write strobe and an output enable. A client issues single-byte read or write requests over a valid/ready handshake. The controller turns each request into a timed pin cycle and returns read bytes with a one-cycle valid pulse.

The memory is organised in rows of eight bytes. The row is every address bit above bit 2. The controller keeps the current row open, with the primary enable held low, for as long as successive requests stay in that row. Requests in the open row are served as column-only page accesses. On a row miss, or after a programmable number of idle cycles, it deselects the memory and waits out the precharge time before it selects the memory again. Writes use write-strobe-controlled timing with output enable held high. A write is complete when its strobe rises, with no polling. All timing limits are parameters counted in clock cycles.

Top module: `pagemem_host`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is closed and fully precharged, or open and waiting. It is low for the whole of every bus cycle.
- R2: When the memory is selected, `mem_addr` has been stable for at least one cycle before `mem_ce1_n` falls, and `mem_ce2` is high.
- R3: A read that opens a row samples `mem_dq_in` on the edge `ACC_CYC` cycles after the edge that lowered `mem_ce1_n`, with `mem_oe_n` low. `rd_data` appears together with a one-cycle `rd_valid` pulse from that edge onward. Exactly one pulse is returned per read, in request order.
- R4: A request whose address bits above bit 2 equal those of the open row leaves `mem_ce1_n` low and the row bits of `mem_addr` unchanged. A page read samples the bus on the edge `PAGE_CYC` cycles after the accepting edge.
- R5: Every written byte gets its own `mem_we_n` low pulse of exactly `WE_CYC` cycles, with `mem_we_n` high for at least one cycle between pulses. Write data is driven and stable for at least `WE_CYC`+1 cycles up to the rising strobe. `mem_oe_n` is high whenever `mem_dq_oe` is high.
- R6: After `mem_ce1_n` rises, it stays high for at least `PRE_CYC`+1 cycles before it falls again. On a row miss the gap is exactly `PRE_CYC`+1 cycles.
- R7: After `IDLE_CYC` consecutive open cycles without a request, `mem_ce1_n` rises. Counted from the edge that completed the last access, it rises on edge `IDLE_CYC`.
- R8: Reset leaves `mem_ce1_n`, `mem_we_n` and `mem_oe_n` high, `mem_dq_oe` and `rd_valid` low, and `req_ready` high.
- R9: In the cycle after the write strobe rises, `req_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Request can be taken this cycle |
| rd_data | output | DATA_W | Returned read byte |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce1_n | output | 1 | Primary chip enable, active low |
| mem_ce2 | output | 1 | Secondary chip enable, active high, held high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Host drives the data pins |
| mem_dq_in | input | DATA_W | Data returned by memory |

## Verification
A read's result is due a fixed number of edges after its trigger. For a row-opening read it is `ACC_CYC` edges after the enable falls. For a page hit it is `PAGE_CYC` edges after the accepting edge. The idle close is due `IDLE_CYC` edges after the last completion. The bench keeps its own edge counter, notes each trigger edge, and compares the edge of each `rd_valid` and enable change with trigger plus latency. Its memory model gives a wrong byte before the access time has elapsed, so sampling early or late fails the data check as well. Inputs change and outputs are observed on the falling clock edge, so every recorded edge number is unambiguous.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // deselected, precharge complete
    ST_PRE,    // deselected, precharge running
    ST_ASU,    // address placed, enable still high
    ST_WSU,    // write data and column placed, strobe high
    ST_WLO,    // write strobe low
    ST_RACC,   // read access time running
    ST_OPEN    // row open, waiting for a request
  } pmc_state_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pmc_down_timer.sv
module pmc_down_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));

  // a zero load would never report completion and hang the sequencer (R3)
  assert_nonzero_load_R3: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));

endmodule

// File: rtl/pmc_idle_timer.sv
module pmc_idle_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);

  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (cnt != W'(LIMIT - 1))
      cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == W'(LIMIT - 1));

endmodule

// File: rtl/pmc_row_match.sv
module pmc_row_match #(
  parameter int ADDR_W = 17,
  parameter int COL_W  = 3
) (
  input  logic [ADDR_W-1:0] req_a,
  input  logic [ADDR_W-1:0] open_a,
  output logic              hit
);

  assign hit = (req_a[ADDR_W-1:COL_W] == open_a[ADDR_W-1:COL_W]);

endmodule

// File: rtl/pagemem_host.sv
module pagemem_host
  import pmc_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int COL_W    = 3,
  parameter int ACC_CYC  = 4,
  parameter int PAGE_CYC = 2,
  parameter int WE_CYC   = 2,
  parameter int PRE_CYC  = 3,
  parameter int IDLE_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int TMR_MAX = max_of4(ACC_CYC, PAGE_CYC, WE_CYC, PRE_CYC);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int GAP_CAP = PRE_CYC + 1;
  localparam int GAP_W   = $clog2(GAP_CAP + 1);

  pmc_state_e state, state_d;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ce1_q, ce1_d;
  logic              we_q, we_d;
  logic              oe_q, oe_d;
  logic [DATA_W-1:0] dqo_q, dqo_d;
  logic              dqoe_q, dqoe_d;
  logic [DATA_W-1:0] rdd_q, rdd_d;
  logic              rv_q, rv_d;
  logic              pv_q, pv_d;
  logic              pw_q, pw_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [DATA_W-1:0] pd_q, pd_d;

  logic              accept;
  logic              row_hit;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_last;
  logic              idle_run;
  logic              idle_expire;

  assign req_ready = (state == ST_IDLE) || (state == ST_OPEN);
  assign accept    = req_valid && req_ready;
  assign idle_run  = (state == ST_OPEN) && !accept;

  pmc_row_match #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_row (
    .req_a  (req_addr),
    .open_a (addr_q),
    .hit    (row_hit)
  );

  pmc_down_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  pmc_idle_timer #(.LIMIT(IDLE_CYC)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .run    (idle_run),
    .expire (idle_expire)
  );

  always_comb begin
    state_d  = state;
    addr_d   = addr_q;
    ce1_d    = ce1_q;
    we_d     = we_q;
    oe_d     = oe_q;
    dqo_d    = dqo_q;
    dqoe_d   = dqoe_q;
    rdd_d    = rdd_q;
    rv_d     = 1'b0;
    pv_d     = pv_q;
    pw_d     = pw_q;
    pa_d     = pa_q;
    pd_d     = pd_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          addr_d  = req_addr;
          pw_d    = req_write;
          pd_d    = req_wdata;
          state_d = ST_ASU;
        end
      end
      ST_PRE: begin
        if (tmr_last) begin
          if (pv_q) begin
            addr_d  = pa_q;
            state_d = ST_ASU;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_ASU: begin
        ce1_d = 1'b0;
        pv_d  = 1'b0;
        if (pw_q) begin
          dqo_d   = pd_q;
          dqoe_d  = 1'b1;
          oe_d    = 1'b1;
          state_d = ST_WSU;
        end else begin
          oe_d     = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(ACC_CYC);
          state_d  = ST_RACC;
        end
      end
      ST_WSU: begin
        we_d     = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(WE_CYC);
        state_d  = ST_WLO;
      end
      ST_WLO: begin
        if (tmr_last) begin
          we_d    = 1'b1;
          state_d = ST_OPEN;
        end
      end
      ST_RACC: begin
        if (tmr_last) begin
          rdd_d   = mem_dq_in;
          rv_d    = 1'b1;
          state_d = ST_OPEN;
        end
      end
      ST_OPEN: begin
        dqoe_d = 1'b0;
        if (accept) begin
          if (row_hit) begin
            addr_d = req_addr;
            if (req_write) begin
              dqo_d   = req_wdata;
              dqoe_d  = 1'b1;
              oe_d    = 1'b1;
              state_d = ST_WSU;
            end else begin
              oe_d     = 1'b0;
              tmr_load = 1'b1;
              tmr_val  = TMR_W'(PAGE_CYC);
              state_d  = ST_RACC;
            end
          end else begin
            ce1_d    = 1'b1;
            oe_d     = 1'b1;
            pv_d     = 1'b1;
            pw_d     = req_write;
            pa_d     = req_addr;
            pd_d     = req_wdata;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(PRE_CYC);
            state_d  = ST_PRE;
          end
        end else if (idle_expire) begin
          ce1_d    = 1'b1;
          oe_d     = 1'b1;
          pv_d     = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(PRE_CYC);
          state_d  = ST_PRE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      ce1_q  <= 1'b1;
      we_q   <= 1'b1;
      oe_q   <= 1'b1;
      dqo_q  <= '0;
      dqoe_q <= 1'b0;
      rdd_q  <= '0;
      rv_q   <= 1'b0;
      pv_q   <= 1'b0;
      pw_q   <= 1'b0;
      pa_q   <= '0;
      pd_q   <= '0;
    end else begin
      state  <= state_d;
      addr_q <= addr_d;
      ce1_q  <= ce1_d;
      we_q   <= we_d;
      oe_q   <= oe_d;
      dqo_q  <= dqo_d;
      dqoe_q <= dqoe_d;
      rdd_q  <= rdd_d;
      rv_q   <= rv_d;
      pv_q   <= pv_d;
      pw_q   <= pw_d;
      pa_q   <= pa_d;
      pd_q   <= pd_d;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_ce1_n  = ce1_q;
  assign mem_ce2    = 1'b1;
  assign mem_we_n   = we_q;
  assign mem_oe_n   = oe_q;
  assign mem_dq_out = dqo_q;
  assign mem_dq_oe  = dqoe_q;
  assign rd_data    = rdd_q;
  assign rd_valid   = rv_q;

  // ---------------------------------------------------------------- checks
  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      gap_cnt <= GAP_W'(GAP_CAP);
    else if (!mem_ce1_n)
      gap_cnt <= '0;
    else if (gap_cnt != GAP_W'(GAP_CAP))
      gap_cnt <= gap_cnt + 1'b1;
  end

  assert_precharge_gap_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce1_n) |-> (gap_cnt == GAP_W'(GAP_CAP)));

  assert_addr_setup_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce1_n) |-> $stable(mem_addr));

  assert_row_held_R4: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce1_n && $past(!mem_ce1_n)) |->
      (mem_addr[ADDR_W-1:COL_W] == $past(mem_addr[ADDR_W-1:COL_W])));

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  assert_strobe_frame_R5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce1_n && mem_dq_oe && !req_ready));

  assert_strobe_gap_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |=> mem_we_n);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  assert_sample_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> ($past(!mem_oe_n) && $past(!mem_ce1_n)));

endmodule

// File: tb/tb_pagemem_host.sv
module tb_pagemem_host;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 7;
  localparam int TA = 3;
  localparam int TP = 2;
  localparam int TW = 2;
  localparam int TR = 2;
  localparam int TI = 6;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          req_ready;
  logic [7:0]    rd_data;
  logic          rd_valid;
  logic [AW-1:0] mem_addr;
  logic          mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]    mem_dq_out;
  logic [7:0]    mem_dq_in = 8'hEE;

  pagemem_host #(
    .ADDR_W(AW), .DATA_W(8), .COL_W(3), .ACC_CYC(TA), .PAGE_CYC(TP),
    .WE_CYC(TW), .PRE_CYC(TR), .IDLE_CYC(TI)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 7) ^ 8'h5A);
  endfunction

  // memory model storage and bench shadow of expected contents
  logic [7:0] mdl [NB];
  logic [7:0] shadow [NB];
  logic [7:0] exp_q [1024];
  int wr_i = 0;
  int rd_i = 0;

  int acc_edge = -1;
  bit acc_rd = 1'b0;

  // monitor and memory model state
  bit            ce_prev = 1'b1;
  bit            we_prev = 1'b1;
  bit            dqoe_prev = 1'b0;
  logic [AW-1:0] addr_prev = '0;
  logic [7:0]    dq_prev = '0;
  logic [AW-4:0] m_row = '0;
  int            m_valid_cyc = 0;
  int            start = 0;
  int            lat = 0;
  int            rise_cyc = -100;
  int            last_rv_cyc = 0;
  int            we_low = 0;
  int            setup_cnt = 0;
  int            last_setup = 0;
  logic [7:0]    last_dq = '0;
  logic [2:0]    last_col = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (cyc == acc_edge && acc_rd) begin
        start = cyc;
        lat = TP;
      end
      if (!mem_ce1_n && mem_addr[2:0] != addr_prev[2:0])
        m_valid_cyc = cyc + TP;
      if (ce_prev && !mem_ce1_n) begin
        chk(mem_addr == addr_prev, "R2 address stable before select", mem_addr, addr_prev);
        chk(mem_ce2 == 1'b1, "R2 secondary enable high", mem_ce2, 1);
        chk(cyc - rise_cyc >= TR + 1, "R6 precharge gap", cyc - rise_cyc, TR + 1);
        m_row = mem_addr[AW-1:3];
        m_valid_cyc = cyc + TA;
        start = cyc;
        lat = TA;
      end
      if (!ce_prev && mem_ce1_n)
        rise_cyc = cyc;
      if (mem_dq_oe && dqoe_prev && mem_dq_out == dq_prev)
        setup_cnt++;
      else
        setup_cnt = mem_dq_oe ? 1 : 0;
      if (!mem_we_n) begin
        if (we_prev) begin
          chk(!mem_ce1_n && mem_oe_n && mem_dq_oe, "R5 strobe framing", {mem_ce1_n, mem_oe_n, mem_dq_oe}, 3'b011);
          chk(mem_addr == addr_prev, "R5 column stable at strobe", mem_addr, addr_prev);
        end
        chk(!req_ready, "R1 ready low in bus cycle", req_ready, 0);
        we_low++;
        last_dq = mem_dq_out;
        last_col = mem_addr[2:0];
        last_setup = setup_cnt;
      end else if (!we_prev) begin
        chk(we_low == TW, "R5 strobe width", we_low, TW);
        chk(last_setup >= TW + 1, "R5 data setup", last_setup, TW + 1);
        chk(req_ready, "R9 ready after strobe rise", req_ready, 1);
        mdl[{m_row, last_col}] = last_dq;
        we_low = 0;
      end
      if (rd_valid) begin
        last_rv_cyc = cyc;
        if (lat == TA)
          chk(cyc == start + lat, "R3 opening read latency", cyc - start, lat);
        else
          chk(cyc == start + lat, "R4 page read latency", cyc - start, lat);
        if (rd_i < wr_i)
          chk(rd_data == exp_q[rd_i], "R3 read data in order", rd_data, exp_q[rd_i]);
        else
          chk(1'b0, "R3 surplus read pulse", rd_i, wr_i);
        rd_i++;
      end
      if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n && cyc >= m_valid_cyc - 1)
        mem_dq_in = mdl[{m_row, mem_addr[2:0]}];
      else
        mem_dq_in = 8'hEE;
      ce_prev = mem_ce1_n;
      we_prev = mem_we_n;
      addr_prev = mem_addr;
      dq_prev = mem_dq_out;
      dqoe_prev = mem_dq_oe;
    end
  end

  task automatic send(input bit w, input int a, input int d);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a[AW-1:0];
    req_wdata = d[7:0];
    while (!req_ready) @(negedge clk);
    acc_edge = cyc + 1;
    acc_rd = !w;
    if (w) shadow[a] = d[7:0];
    else begin
      exp_q[wr_i] = shadow[a];
      wr_i++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog R1: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      mdl[i] = init_val(i);
      shadow[i] = init_val(i);
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    chk(mem_ce1_n && mem_we_n && mem_oe_n, "R8 strobes idle", {mem_ce1_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!mem_dq_oe && !rd_valid, "R8 bus released", {mem_dq_oe, rd_valid}, 0);
    chk(req_ready, "R8 ready after reset", req_ready, 1);

    // R3 opening read from closed state
    send(1'b0, 0, 0);
    // R4 R5 sequential write sweep: page hits with a miss every eight bytes
    for (int a = 0; a < NB; a++) send(1'b1, a, (a * 29 + 3) & 255);
    // R4 sequential read sweep
    for (int a = 0; a < NB; a++) send(1'b0, a, 0);
    // R6 strided reads: every access changes row
    for (int i = 0; i < NB; i++) send(1'b0, (i % 16) * 8 + (i / 16), 0);
    // R5 R9 interleaved page write then read of the same byte
    for (int r = 0; r < NB / 8; r++)
      for (int c = 0; c < 8; c++) begin
        send(1'b1, r * 8 + c, ((r * 8 + c) ^ 8'hA5) + r);
        send(1'b0, r * 8 + c, 0);
      end
    // R4 repeated reads of one address with no column change
    for (int k = 0; k < 4; k++) send(1'b0, 77, 0);
    // R7 idle close after a read
    repeat (TI + 10) @(negedge clk);
    send(1'b0, 42, 0);
    repeat (TA + TI + 6) @(negedge clk);
    chk(rise_cyc == last_rv_cyc + TI, "R7 idle close edge", rise_cyc - last_rv_cyc, TI);
    chk(mem_ce1_n == 1'b1, "R7 deselected after idle", mem_ce1_n, 1);
    // R3 reopen after idle close, then a miss write and readback
    send(1'b0, 43, 0);
    send(1'b1, 120, 8'h3C);
    send(1'b0, 120, 0);
    repeat (20) @(negedge clk);
    chk(rd_i == wr_i, "R3 one pulse per read", rd_i, wr_i);
    finish_run();
  end

endmodule